// File: doc/BRIEF.md
# Thermal Fan Level Controller with Hysteresis

This block turns a stream of temperature readings into a fan drive signal. Readings arrive as signed words in millidegrees Celsius, each marked by a one-cycle valid strobe. The block keeps the newest reading and evaluates it once per evaluation interval (1000 ms by default). The evaluation picks one of four cooling states from three rising trip points. A hysteresis band below each trip stops the fan from toggling when the temperature hovers near a threshold.

Each cooling state selects an 8-bit duty level on a non-linear curve. A free-running counter compares against that level to produce the fan PWM waveform, which has normal polarity and a period of about 10 ms. The millisecond time base, the evaluation interval and the PWM step all come from the input clock through prescaler parameters. The temperature sensor and the pad setup sit outside this block.

Top module: `fan_thermal_ctrl`

## Requirements
- R1: After reset, state_o is 0 and level_o is 0. pwm_o stays low until the first valid sample has been evaluated.
- R2: The state is evaluated on one clock cycle every EVAL_MS milliseconds, where one millisecond is CLK_PER_MS clocks. state_o changes only on the cycle after such an evaluation.
- R3: A sample is captured only on a cycle where temp_valid_i is 1. The most recent captured sample is used at the next evaluation. If no sample was captured since the last evaluation, the state is held, whatever temp_i carries.
- R4: Rising: the state becomes the number of trip points (39000, 50000, 60000 m°C) that the sample reaches or exceeds, whenever that number is above the current state. A sample equal to a trip counts as reaching it.
- R5: Falling: state k is kept while the sample is at or above trip k minus 5000 m°C (34000, 45000, 55000). Below that value the state drops to the highest level whose release threshold still holds, so it may drop several levels at once.
- R6: temp_i is a two's-complement signed value, so negative temperatures compare below every trip.
- R7: level_o is 0, 66, 196 and 255 for states 0, 1, 2 and 3.
- R8: The PWM period is 255 steps. pwm_o is high for level_o steps per period, so level 0 is never high and level 255 is always high.
- R9: One PWM step lasts CLK_PER_MS*PWM_MS/255 clocks, with a minimum of 1 clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| temp_i | input | TEMP_W | Signed temperature, m°C |
| temp_valid_i | input | 1 | Sample strobe for temp_i |
| state_o | output | 2 | Current cooling state 0..3 |
| level_o | output | 8 | Duty level of the current state |
| pwm_o | output | 1 | Fan PWM, active high |

## Verification
The checker assumes that temp_valid_i is a clean synchronous strobe and that temp_i only matters on strobe cycles. It also assumes that no evaluation falls between reset release and the point where the bench starts counting. The bench drives each sample for exactly one cycle at the falling edge, then waits three full evaluation intervals before sampling the outputs. This keeps every check independent of where the evaluation tick falls relative to the strobe. Duty is measured over exactly one 255-clock PWM period, so the result does not depend on the counter's phase.

// File: rtl/fan_ctrl_pkg.sv
package fan_ctrl_pkg;
  localparam int unsigned N_TRIP  = 3;
  localparam int unsigned STATE_W = 2;
  localparam int unsigned LEVEL_W = 8;
  localparam int unsigned PWM_STEPS = (1 << LEVEL_W) - 1;

  typedef logic [STATE_W-1:0] cool_state_t;
  typedef logic [LEVEL_W-1:0] duty_t;

  function automatic int unsigned cnt_w(input int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/fan_tick_gen.sv
module fan_tick_gen #(
  parameter int unsigned CLK_PER_MS = 50000,
  parameter int unsigned EVAL_MS    = 1000,
  parameter int unsigned STEP_DIV   = 1961
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic eval_tick_o,
  output logic pwm_step_o
);
  import fan_ctrl_pkg::*;

  localparam int unsigned CW = cnt_w(CLK_PER_MS);
  localparam int unsigned MW = cnt_w(EVAL_MS);
  localparam int unsigned SW = cnt_w(STEP_DIV);

  logic [CW-1:0] clk_cnt_q;
  logic [MW-1:0] ms_cnt_q;
  logic          ms_wrap;

  assign ms_wrap     = (clk_cnt_q == CW'(CLK_PER_MS - 1));
  assign eval_tick_o = ms_wrap && (ms_cnt_q == MW'(EVAL_MS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_cnt_q <= '0;
      ms_cnt_q  <= '0;
    end else begin
      clk_cnt_q <= ms_wrap ? '0 : clk_cnt_q + 1'b1;
      if (ms_wrap) ms_cnt_q <= eval_tick_o ? '0 : ms_cnt_q + 1'b1;
    end
  end

  generate
    if (STEP_DIV <= 1) begin : g_step_every
      assign pwm_step_o = 1'b1;
    end else begin : g_step_div
      logic [SW-1:0] step_cnt_q;
      assign pwm_step_o = (step_cnt_q == SW'(STEP_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) step_cnt_q <= '0;
        else         step_cnt_q <= pwm_step_o ? '0 : step_cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/fan_trip_fsm.sv
module fan_trip_fsm
  import fan_ctrl_pkg::*;
#(
  parameter int unsigned TEMP_W = 32,
  parameter logic [N_TRIP-1:0][TEMP_W-1:0] TRIPS = '0,
  parameter int unsigned HYST = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              valid_i,
  input  logic              eval_tick_i,
  output cool_state_t       state_o,
  output logic              armed_o,
  output logic              pending_o
);
  localparam int unsigned EXT_W = TEMP_W + 2;

  logic [TEMP_W-1:0]       sample_q;
  logic                    pending_q, armed_q;
  cool_state_t             state_q, state_d;
  logic signed [EXT_W-1:0] smp_ext;
  logic [N_TRIP-1:0]       hit_up, hit_dn;

  assign smp_ext = EXT_W'($signed(sample_q));

  generate
    for (genvar i = 0; i < N_TRIP; i++) begin : g_cmp
      localparam logic signed [EXT_W-1:0] UP = EXT_W'($signed(TRIPS[i]));
      localparam logic signed [EXT_W-1:0] DN = UP - EXT_W'(HYST);
      assign hit_up[i] = (smp_ext >= UP);
      // release threshold only matters for levels already engaged
      assign hit_dn[i] = (smp_ext >= DN) && (STATE_W'(i) < state_q);
    end
  endgenerate

  always_comb begin
    cool_state_t up_n, dn_n;
    up_n = '0;
    dn_n = '0;
    for (int i = 0; i < N_TRIP; i++) begin
      up_n = up_n + STATE_W'(hit_up[i]);
      dn_n = dn_n + STATE_W'(hit_dn[i]);
    end
    state_d = (up_n > dn_n) ? up_n : dn_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q  <= '0;
      pending_q <= 1'b0;
      armed_q   <= 1'b0;
      state_q   <= '0;
    end else begin
      if (eval_tick_i && pending_q) begin
        state_q <= state_d;
        armed_q <= 1'b1;
      end
      if (valid_i) begin
        sample_q  <= temp_i;
        pending_q <= 1'b1;
      end else if (eval_tick_i) begin
        pending_q <= 1'b0;
      end
    end
  end

  assign state_o   = state_q;
  assign armed_o   = armed_q;
  assign pending_o = pending_q;
endmodule

// File: rtl/fan_level_lut.sv
module fan_level_lut
  import fan_ctrl_pkg::*;
#(
  parameter logic [N_TRIP:0][LEVEL_W-1:0] LEVELS = '0
) (
  input  cool_state_t state_i,
  output duty_t       level_o
);
  assign level_o = LEVELS[state_i];
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fan_ctrl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  step_i,
  input  logic  enable_i,
  input  duty_t level_i,
  output logic  pwm_o
);
  duty_t cnt_q;
  logic  pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      if (step_i) cnt_q <= (cnt_q == duty_t'(PWM_STEPS - 1)) ? '0 : cnt_q + 1'b1;
      pwm_q <= enable_i && (cnt_q < level_i);
    end
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/fan_thermal_ctrl.sv
module fan_thermal_ctrl
  import fan_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PER_MS = 50000,
  parameter int unsigned EVAL_MS    = 1000,
  parameter int unsigned PWM_MS     = 10,
  parameter int unsigned TEMP_W     = 32,
  parameter int          TRIP_LO    = 39000,
  parameter int          TRIP_MID   = 50000,
  parameter int          TRIP_HI    = 60000,
  parameter int unsigned HYST       = 5000,
  parameter int unsigned LVL_1      = 66,
  parameter int unsigned LVL_2      = 196,
  parameter int unsigned LVL_3      = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              temp_valid_i,
  output logic [1:0]        state_o,
  output logic [7:0]        level_o,
  output logic              pwm_o
);
  localparam int unsigned STEP_RAW = (CLK_PER_MS * PWM_MS) / PWM_STEPS;
  localparam int unsigned STEP_DIV = (STEP_RAW < 1) ? 1 : STEP_RAW;
  localparam logic [N_TRIP-1:0][TEMP_W-1:0] TRIPS =
    {TEMP_W'(TRIP_HI), TEMP_W'(TRIP_MID), TEMP_W'(TRIP_LO)};
  localparam logic [N_TRIP:0][LEVEL_W-1:0] LEVELS =
    {LEVEL_W'(LVL_3), LEVEL_W'(LVL_2), LEVEL_W'(LVL_1), LEVEL_W'(0)};

  logic        eval_tick, pwm_step, armed, pending;
  cool_state_t state;
  duty_t       level;

  fan_tick_gen #(
    .CLK_PER_MS(CLK_PER_MS), .EVAL_MS(EVAL_MS), .STEP_DIV(STEP_DIV)
  ) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .eval_tick_o(eval_tick), .pwm_step_o(pwm_step)
  );

  fan_trip_fsm #(
    .TEMP_W(TEMP_W), .TRIPS(TRIPS), .HYST(HYST)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .temp_i(temp_i), .valid_i(temp_valid_i),
    .eval_tick_i(eval_tick), .state_o(state), .armed_o(armed), .pending_o(pending)
  );

  fan_level_lut #(.LEVELS(LEVELS)) u_lut (.state_i(state), .level_o(level));

  fan_pwm_gen u_pwm (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(pwm_step),
    .enable_i(armed), .level_i(level), .pwm_o(pwm_o)
  );

  assign state_o = state;
  assign level_o = level;
endmodule

// File: rtl/fan_thermal_ctrl_chk.sv
module fan_thermal_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       eval_tick,
  input logic       pending,
  input logic       armed,
  input logic [1:0] state_o,
  input logic [7:0] level_o,
  input logic       pwm_o
);
  // R2
  state_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_tick |=> $stable(state_o));
  // R3
  hold_no_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_tick && !pending) |=> $stable(state_o));
  // R1
  low_until_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |=> !pwm_o);
  // R8
  zero_level_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == 8'd0) |=> !pwm_o);
  // R8
  full_level_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && level_o == 8'hFF) |=> pwm_o);
endmodule

bind fan_thermal_ctrl fan_thermal_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .eval_tick(eval_tick), .pending(pending),
  .armed(armed), .state_o(state_o), .level_o(level_o), .pwm_o(pwm_o)
);

// File: tb/fan_thermal_ctrl_test.sv
`timescale 1ns/1ps
module fan_thermal_ctrl_test;
  localparam int CLK_PER_MS = 4;
  localparam int EVAL_MS    = 5;
  localparam int EVAL_CLK   = CLK_PER_MS * EVAL_MS;
  localparam int SETTLE     = 3 * EVAL_CLK;
  localparam int N_VEC      = 16;
  // {temperature, expected state, expected level}
  localparam int VEC [N_VEC][3] = '{
    '{ 20000, 0,   0}, '{ 39000, 1,  66}, '{ 38999, 1,  66}, '{ 34000, 1,  66},
    '{ 33999, 0,   0}, '{ 50000, 2, 196}, '{ 45000, 2, 196}, '{ 44999, 1,  66},
    '{ 60000, 3, 255}, '{ 55000, 3, 255}, '{ 54999, 2, 196}, '{ 70000, 3, 255},
    '{ -5000, 0,   0}, '{ 49999, 1,  66}, '{ 80000, 3, 255}, '{   100, 0,   0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] temp_i = '0;
  logic        temp_valid_i = 1'b0;
  logic [1:0]  state_o;
  logic [7:0]  level_o;
  logic        pwm_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  fan_thermal_ctrl #(.CLK_PER_MS(CLK_PER_MS), .EVAL_MS(EVAL_MS), .PWM_MS(10)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .temp_i(temp_i), .temp_valid_i(temp_valid_i),
    .state_o(state_o), .level_o(level_o), .pwm_o(pwm_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int t);
    @(negedge clk_i);
    temp_i = t;
    temp_valid_i = 1'b1;
    @(negedge clk_i);
    temp_valid_i = 1'b0;
    repeat (SETTLE) @(negedge clk_i);
  endtask

  task automatic duty(output int highs);
    highs = 0;
    for (int i = 0; i < 255; i++) begin
      @(negedge clk_i);
      if (pwm_o) highs++;
    end
  endtask

  initial begin
    int h;
    repeat (3) @(negedge clk_i);
    // R1 reset values
    chk("R1 state", state_o, 0);
    chk("R1 level", level_o, 0);
    rst_ni = 1'b1;
    // R1 pwm low before first evaluated sample
    duty(h);
    chk("R1 pwm before sample", h, 0);

    // R4 R5 R6 R7 table walk
    for (int v = 0; v < N_VEC; v++) begin
      send(VEC[v][0]);
      chk($sformatf("R4/R5/R6 state vec %0d", v), state_o, VEC[v][1]);
      chk($sformatf("R7 level vec %0d", v), level_o, VEC[v][2]);
    end

    // R8 R9 duty per state, one 255-clock period
    send(39500); duty(h); chk("R8 R9 duty state1", h, 66);
    send(52000); duty(h); chk("R8 R9 duty state2", h, 196);
    send(61000); duty(h); chk("R8 R9 duty state3", h, 255);
    send(10000); duty(h); chk("R8 duty state0", h, 0);

    // R3 temp_i without strobe is ignored, state held across many evals
    send(55000);
    chk("R3 setup", state_o, 2);
    @(negedge clk_i);
    temp_i = 90000;
    repeat (6 * EVAL_CLK) @(negedge clk_i);
    chk("R3 no strobe hold", state_o, 2);
    chk("R3 no strobe level", level_o, 196);

    // R3 latest of two strobes wins
    @(negedge clk_i);
    temp_i = 65000; temp_valid_i = 1'b1;
    @(negedge clk_i);
    temp_i = 52000;
    @(negedge clk_i);
    temp_valid_i = 1'b0;
    repeat (SETTLE) @(negedge clk_i);
    chk("R3 latest sample", state_o, 2);

    // R2 state waits for the evaluation tick
    send(0);
    chk("R2 setup", state_o, 0);
    @(negedge clk_i);
    temp_i = 70000; temp_valid_i = 1'b1;
    @(negedge clk_i);
    temp_valid_i = 1'b0;
    begin
      int lat = 0;
      while (state_o == 2'd0 && lat < 2 * EVAL_CLK) begin
        @(negedge clk_i);
        lat++;
      end
      n_chk++;
      if (lat < 1 || lat > EVAL_CLK) begin
        n_fail++;
        $display("FAIL R2 latency: actual %0d expected 1..%0d", lat, EVAL_CLK);
      end
      repeat (EVAL_CLK - 1) @(negedge clk_i);
      chk("R2 state after tick", state_o, 3);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule